// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is the slave side of a two-wire serial bus. It models a 256-byte non-volatile memory as a register array. The bus clock and data lines come in through a synchronizer clocked by the system clock. The slave drives the data line only by pulling it low, through an output-enable that the pad or the bench combines with the bus pull-up. It recognises start and stop conditions and compares the address byte against a fixed device code and three strap inputs. Once addressed, it serves byte writes, page writes of up to eight bytes, current-address reads, random reads and sequential reads.

Written bytes are collected in a one-page buffer. They reach the array only when a stop condition closes the transaction. A stop that follows at least one complete data byte starts a self-timed write cycle of `WRITE_CYCLES` system clocks. While that cycle runs the slave ignores the bus entirely, so a master finds out that the write has finished by repeating the address byte until it is acknowledged. A write-protect input shields the upper half of the array. Protected bytes are still acknowledged on the bus but are never stored.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset the slave does not pull SDA low, every byte of the array reads 0xFF, and no write cycle is running, so an address byte is acknowledged at once.
- R2: The address byte is sent MSB first. It is acknowledged by SDA low during the ninth SCL high phase only when bits 7..4 are 1010 and bits 3..1 equal strap_i[2:0]. Bit 0 is the direction: 1 means read, 0 means write. On a mismatch the slave does not acknowledge, and it ignores every following byte until the next start condition.
- R3: A write transaction consists of the address byte, a word address and one data byte, each acknowledged. When it is closed by a stop, the byte is stored at that word address.
- R4: Each data byte of a write advances only bits 2..0 of the word address. Bits 7..3 stay fixed, so a ninth byte wraps to the start of the same 8-byte page and overwrites the first byte written there.
- R5: A stop after one or more complete data bytes starts a write cycle of WRITE_CYCLES system clocks. During that cycle SDA is never pulled low and address bytes are not acknowledged. After the cycle ends, an address byte is acknowledged again.
- R6: The address counter holds the last accessed address plus one. After a write the increment wraps within the page. A current-address read (an address byte with bit 0 set, sent directly after a start) returns the byte at the counter.
- R7: A random read, made of a write of the word address, a repeated start and a read address byte, returns the byte at that word address.
- R8: In a read, each master acknowledge (SDA low in the ninth clock) makes the slave send the next byte. The address counts across the whole array, from 0xFF to 0x00. A master non-acknowledge ends the read.
- R9: While wp_i is high, data bytes aimed at 0x80..0xFF are acknowledged but not stored, and bytes aimed at 0x00..0x7F are still stored. While wp_i is low, the whole array is writable.
- R10: Data reaches the array only on a stop. A repeated start discards the buffered bytes and starts no write cycle. A stop that follows only a word address starts no write cycle either.
- R11: The slave changes its drive of SDA only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_oe | output | 1 | High pulls the data line low |
| wp_i | input | 1 | Write protect for the upper half of the array |
| strap_i | input | 3 | Hard-wired device address bits compared with address bits 3..1 |

## Verification
Bus levels reach the control logic two system clocks after they change at the pad. The slave's acknowledge or read data bit therefore appears on the line three system clocks after an SCL falling edge. The bench holds each SCL low phase for ten clocks and samples the line five clocks into the high phase, well after the drive has settled and before SCL falls again. A write becomes visible only after its stop plus WRITE_CYCLES clocks, so every read-back is preceded by an address byte sent right after the stop, which must not be acknowledged, and then by acknowledge polling until one is.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
   localparam int TW_BYTE = 8;
   localparam logic [3:0] TW_DEV_CODE = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADDR,
      ST_WDATA,
      ST_RD,
      ST_WAIT
   } tw_state_t;
endpackage

// File: rtl/tw_sync.sv
`timescale 1ns/1ps
module tw_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   // STAGES flops for metastability, one more holding the previous level
   logic [STAGES:0][W-1:0] pipe;

   initial assert (STAGES >= 2) else $error("tw_sync: STAGES must be at least 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-1:0], d};
   end

   assign q      = pipe[STAGES-1];
   assign q_prev = pipe[STAGES];
endmodule

// File: rtl/tw_store.sv
`timescale 1ns/1ps
module tw_store #(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 3,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     buf_clr,
   input  logic                     buf_wr,
   input  logic [PAGE_W-1:0]        buf_off,
   input  logic [DATA_W-1:0]        buf_data,
   input  logic                     commit,
   input  logic [ADDR_W-PAGE_W-1:0] page,
   input  logic                     wp,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     any_valid
);
   localparam int PAGE_LEN = 1 << PAGE_W;
   localparam int ROWS     = 1 << (ADDR_W - PAGE_W);

   logic [PAGE_LEN-1:0]             valid_vec;
   logic [PAGE_LEN-1:0][DATA_W-1:0] lane_q;
   logic                            blocked;
   logic [ADDR_W-PAGE_W-1:0]        rd_row;
   logic [PAGE_W-1:0]               rd_off;

   // pages never straddle the halves, so the page MSB decides protection
   assign blocked = wp & page[ADDR_W-PAGE_W-1];
   assign rd_row  = rd_addr[ADDR_W-1:PAGE_W];
   assign rd_off  = rd_addr[PAGE_W-1:0];

   // one lane per byte offset in a page: its buffer slot and its column of the array
   for (genvar l = 0; l < PAGE_LEN; l++) begin : g_lane
      logic              v;
      logic [DATA_W-1:0] d;
      logic [DATA_W-1:0] col [ROWS];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v <= 1'b0;
            d <= '0;
         end else if (buf_clr || commit) begin
            v <= 1'b0;
         end else if (buf_wr && buf_off == PAGE_W'(l)) begin
            v <= 1'b1;
            d <= buf_data;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) col[r] <= '1;
         end else if (commit && v && !blocked) begin
            col[page] <= d;
         end
      end

      assign valid_vec[l] = v;
      assign lane_q[l]    = col[rd_row];
   end

   assign rd_data   = lane_q[rd_off];
   assign any_valid = |valid_vec;
endmodule

// File: rtl/tw_ctrl.sv
`timescale 1ns/1ps
module tw_ctrl
   import tw_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int PAGE_W       = 3,
   parameter int WRITE_CYCLES = 400
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     scl,
   input  logic                     scl_prev,
   input  logic                     sda,
   input  logic                     sda_prev,
   input  logic [2:0]               strap,
   input  logic [TW_BYTE-1:0]       rd_data,
   input  logic                     any_valid,
   output logic                     sda_oe,
   output logic                     buf_clr,
   output logic                     buf_wr,
   output logic [PAGE_W-1:0]        buf_off,
   output logic [TW_BYTE-1:0]       buf_data,
   output logic                     commit,
   output logic [ADDR_W-PAGE_W-1:0] page,
   output logic [ADDR_W-1:0]        addr_cnt,
   output logic                     busy,
   output logic                     stop_det,
   output tw_state_t                state
);
   localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

   logic               scl_rise, scl_fall, start_det;
   logic [3:0]         bitcnt;
   logic [TW_BYTE-1:0] shreg;
   logic [TW_BYTE-2:0] tx;
   logic               mack;
   logic [CNT_W-1:0]   wcnt;

   assign scl_rise  = scl & ~scl_prev;
   assign scl_fall  = ~scl & scl_prev;
   assign start_det = scl & scl_prev & sda_prev & ~sda;
   assign stop_det  = scl & scl_prev & ~sda_prev & sda;

   assign busy     = (wcnt != '0);
   assign commit   = stop_det & any_valid & ~busy;
   assign buf_clr  = start_det & ~busy;
   assign buf_wr   = (state == ST_WDATA) && scl_fall && (bitcnt == 4'd8)
                     && !busy && !start_det && !stop_det;
   assign buf_off  = addr_cnt[PAGE_W-1:0];
   assign buf_data = shreg;
   assign page     = addr_cnt[ADDR_W-1:PAGE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wcnt <= '0;
      else if (commit) wcnt <= CNT_W'(WRITE_CYCLES);
      else if (busy)   wcnt <= wcnt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         tx       <= '0;
         mack     <= 1'b1;
         sda_oe   <= 1'b0;
         addr_cnt <= '0;
      end else if (busy) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else if (start_det) begin
         state  <= ST_DEV;
         bitcnt <= '0;
         sda_oe <= 1'b0;
      end else if (stop_det) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else if (state != ST_IDLE && state != ST_WAIT) begin
         if (scl_rise) begin
            if (bitcnt < 4'd8) shreg <= {shreg[TW_BYTE-2:0], sda};
            if (bitcnt == 4'd8) mack <= sda;
            if (bitcnt < 4'd9) bitcnt <= bitcnt + 1'b1;
         end
         if (scl_fall) begin
            if (bitcnt == 4'd8) begin
               // a byte is complete: decide the ninth clock
               case (state)
                  ST_DEV: begin
                     if (shreg[7:4] == TW_DEV_CODE && shreg[3:1] == strap) begin
                        sda_oe <= 1'b1;
                        state  <= shreg[0] ? ST_RD : ST_WADDR;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
                  ST_WADDR: begin
                     sda_oe   <= 1'b1;
                     addr_cnt <= shreg[ADDR_W-1:0];
                     state    <= ST_WDATA;
                  end
                  ST_WDATA: begin
                     sda_oe <= 1'b1;
                     addr_cnt[PAGE_W-1:0] <= addr_cnt[PAGE_W-1:0] + 1'b1;
                  end
                  default: sda_oe <= 1'b0;
               endcase
            end else if (bitcnt == 4'd9) begin
               bitcnt <= '0;
               if (state == ST_RD && !mack) begin
                  tx       <= rd_data[TW_BYTE-2:0];
                  sda_oe   <= ~rd_data[TW_BYTE-1];
                  addr_cnt <= addr_cnt + 1'b1;
               end else begin
                  sda_oe <= 1'b0;
                  if (state == ST_RD) state <= ST_WAIT;
               end
            end else if (bitcnt != 4'd0 && state == ST_RD) begin
               sda_oe <= ~tx[TW_BYTE-2];
               tx     <= {tx[TW_BYTE-3:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/tw_eeprom_slave.sv
`timescale 1ns/1ps
module tw_eeprom_slave
   import tw_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int PAGE_W       = 3,
   parameter int SYNC_STAGES  = 2,
   parameter int WRITE_CYCLES = 400
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic       wp_i,
   input  logic [2:0] strap_i
);
   initial begin
      assert (ADDR_W <= TW_BYTE) else $error("tw_eeprom_slave: word address wider than a byte");
      assert (PAGE_W >= 1 && PAGE_W < ADDR_W) else $error("tw_eeprom_slave: bad page width");
      assert (WRITE_CYCLES >= 1) else $error("tw_eeprom_slave: write cycle must be non-zero");
   end

   logic                     scl_s, scl_p, sda_s, sda_p;
   logic                     buf_clr, buf_wr, commit, any_valid, busy, stop_det;
   logic [PAGE_W-1:0]        buf_off;
   logic [TW_BYTE-1:0]       buf_data, rd_data;
   logic [ADDR_W-PAGE_W-1:0] page;
   logic [ADDR_W-1:0]        addr_cnt;
   tw_state_t                state;

   tw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}),
      .q({scl_s, sda_s}), .q_prev({scl_p, sda_p})
   );

   tw_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .scl(scl_s), .scl_prev(scl_p),
      .sda(sda_s), .sda_prev(sda_p), .strap(strap_i), .rd_data(rd_data),
      .any_valid(any_valid), .sda_oe(sda_oe), .buf_clr(buf_clr), .buf_wr(buf_wr),
      .buf_off(buf_off), .buf_data(buf_data), .commit(commit), .page(page),
      .addr_cnt(addr_cnt), .busy(busy), .stop_det(stop_det), .state(state)
   );

   tw_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(TW_BYTE)) u_store (
      .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_wr(buf_wr),
      .buf_off(buf_off), .buf_data(buf_data), .commit(commit), .page(page),
      .wp(wp_i), .rd_addr(addr_cnt), .rd_data(rd_data), .any_valid(any_valid)
   );
endmodule

// File: rtl/tw_eeprom_chk.sv
`timescale 1ns/1ps
module tw_eeprom_chk
   import tw_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sda_oe,
   input logic              scl_s,
   input logic              busy,
   input logic              stop_det,
   input tw_state_t         state,
   input logic [ADDR_W-1:0] addr_cnt
);
   assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_s));

   assert_silent_in_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe);

   assert_cycle_from_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_det));

   assert_page_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WDATA && $past(state) == ST_WDATA)
      |-> addr_cnt[ADDR_W-1:PAGE_W] == $past(addr_cnt[ADDR_W-1:PAGE_W]));

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && $past(state) == ST_IDLE) |-> !sda_oe);
endmodule

bind tw_eeprom_slave tw_eeprom_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s), .busy(busy),
   .stop_det(stop_det), .state(state), .addr_cnt(addr_cnt)
);

// File: tb/sim_tw_eeprom_slave.sv
`timescale 1ns/1ps
module sim_tw_eeprom_slave;
   localparam int QTR = 5;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
   localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

   // {word address, data, wp, expected read-back}
   localparam logic [24:0] VEC [6] = '{
      {8'h10, 8'hA5, 1'b0, 8'hA5},
      {8'h90, 8'h3C, 1'b0, 8'h3C},
      {8'h90, 8'h77, 1'b1, 8'h3C},
      {8'h7F, 8'h5A, 1'b1, 8'h5A},
      {8'hFF, 8'h12, 1'b1, 8'hFF},
      {8'h00, 8'hC3, 1'b0, 8'hC3}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic wp = 1'b0;
   logic sda_oe;
   wire  sda_bus = sda_m & ~sda_oe;

   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;
   logic ack, seen;
   logic [7:0] rb [8];
   logic [7:0] pg [9];
   int   tries;

   always #10 clk = ~clk;

   tw_eeprom_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe(sda_oe), .wp_i(wp), .strap_i(STRAP)
   );

   task automatic wc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start;
      sda_m = 1'b1; wc(QTR);
      scl_m = 1'b1; wc(2*QTR);
      sda_m = 1'b0; wc(2*QTR);
      scl_m = 1'b0; wc(QTR);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; wc(QTR);
      scl_m = 1'b1; wc(2*QTR);
      sda_m = 1'b1; wc(2*QTR);
   endtask

   task automatic clk_bit(input logic b, output logic s);
      sda_m = b; wc(2*QTR);
      scl_m = 1'b1; wc(QTR);
      s = sda_bus; wc(QTR);
      scl_m = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic a);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      a = ~s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         b[i] = s;
      end
      clk_bit(~give_ack, s);
   endtask

   task automatic poll_ready(output int t);
      logic a;
      t = 0;
      a = 1'b0;
      while (!a && t < 50) begin
         bus_start;
         send_byte(DEV_W, a);
         bus_stop;
         t++;
      end
   endtask

   task automatic rand_read(input logic [7:0] wa, input int n, output logic [7:0] r [8]);
      logic a;
      bus_start;
      send_byte(DEV_W, a);
      send_byte(wa, a);
      bus_start;
      send_byte(DEV_R, a);
      for (int k = 0; k < n; k++) recv_byte(k < n - 1, r[k]);
      bus_stop;
   endtask

   initial begin
      wc(2000000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      wc(5);
      chk("R1 sda released in reset", int'(sda_oe), 0);
      rst_n = 1'b1;
      wc(5);
      chk("R1 sda released after reset", int'(sda_oe), 0);

      // R1: fresh array and no pending cycle
      bus_start;
      send_byte(DEV_R, ack);
      chk("R1 address ack after reset", int'(ack), 1);
      recv_byte(1'b1, rb[0]);
      recv_byte(1'b0, rb[1]);
      bus_stop;
      chk("R1 byte 0 erased", int'(rb[0]), 'hFF);
      chk("R1 byte 1 erased", int'(rb[1]), 'hFF);

      // R2: wrong strap bits, following bytes ignored
      bus_start;
      send_byte({4'b1010, 3'b100, 1'b0}, ack);
      chk("R2 mismatch not acked", int'(ack), 0);
      send_byte(8'h30, ack);
      chk("R2 word after mismatch ignored", int'(ack), 0);
      send_byte(8'h55, ack);
      bus_stop;
      rand_read(8'h30, 1, rb);
      chk("R2 nothing written after mismatch", int'(rb[0]), 'hFF);

      // vector walk: single-byte writes, with and without protection
      foreach (VEC[v]) begin
         wp = VEC[v][8];
         bus_start;
         send_byte(DEV_W, ack);
         chk("R2 matching address acked", int'(ack), 1);
         send_byte(VEC[v][24:17], ack);
         send_byte(VEC[v][16:9], ack);
         chk(VEC[v][8] ? "R9 protected byte acked" : "R3 data byte acked", int'(ack), 1);
         bus_stop;
         poll_ready(tries);
         wp = 1'b0;
         rand_read(VEC[v][24:17], 1, rb);
         chk(VEC[v][8] ? "R9 read-back under wp" : "R3 read-back", int'(rb[0]), int'(VEC[v][7:0]));
      end

      // R5: right after a committing stop the slave stays silent, then answers
      bus_start;
      send_byte(DEV_W, ack);
      send_byte(8'h40, ack);
      send_byte(8'h66, ack);
      bus_stop;
      bus_start;
      send_byte(DEV_W, ack);
      chk("R5 no ack during write cycle", int'(ack), 0);
      bus_stop;
      poll_ready(tries);
      chk("R5 ack after write cycle", int'(tries < 50), 1);

      // R10: dummy write starts no cycle
      bus_start;
      send_byte(DEV_W, ack);
      send_byte(8'h20, ack);
      bus_stop;
      bus_start;
      send_byte(DEV_W, ack);
      chk("R10 ack right after dummy write", int'(ack), 1);
      bus_stop;

      // R10: repeated start discards buffered data
      bus_start;
      send_byte(DEV_W, ack);
      send_byte(8'h20, ack);
      send_byte(8'h99, ack);
      bus_start;
      send_byte(DEV_R, ack);
      recv_byte(1'b0, rb[0]);
      bus_stop;
      bus_start;
      send_byte(DEV_W, ack);
      chk("R10 no cycle after repeated start", int'(ack), 1);
      bus_stop;
      rand_read(8'h20, 1, rb);
      chk("R10 discarded byte not stored", int'(rb[0]), 'hFF);

      // R4: nine bytes from 0xFA wrap inside page 0xF8..0xFF
      for (int i = 0; i < 9; i++) pg[i] = 8'h40 + 8'(i);
      bus_start;
      send_byte(DEV_W, ack);
      send_byte(8'hFA, ack);
      for (int i = 0; i < 9; i++) send_byte(pg[i], ack);
      bus_stop;
      poll_ready(tries);

      // R6: counter is last written (0xFA) plus one
      bus_start;
      send_byte(DEV_R, ack);
      recv_byte(1'b0, rb[0]);
      bus_stop;
      chk("R6 current-address read", int'(rb[0]), 'h41);

      rand_read(8'hF8, 8, rb);
      chk("R4 byte F8", int'(rb[0]), 'h46);
      chk("R4 byte F9", int'(rb[1]), 'h47);
      chk("R4 byte FA overwritten", int'(rb[2]), 'h48);
      chk("R4 byte FB", int'(rb[3]), 'h41);
      chk("R4 byte FF", int'(rb[7]), 'h45);

      // R7 and R8: random read then sequential across the top of the array
      rand_read(8'hFE, 4, rb);
      chk("R7 random read FE", int'(rb[0]), 'h44);
      chk("R8 sequential FF", int'(rb[1]), 'h45);
      chk("R8 rollover to 00", int'(rb[2]), 'hC3);
      chk("R8 sequential 01", int'(rb[3]), 'hFF);
      wc(3);
      chk("R8 released after nack", int'(sda_oe), 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule